// File: doc/BRIEF.md
# Multi-Mode Interrupt Output Controller

This block drives a single active-low, open-drain interrupt line. It produces an active-high pull-low enable and does not drive a pin level. Three mode bits (arm, minute, free-run) select one of five behaviours:
- no output;
- a clock built from a 32.768 kHz divider chain;
- a sticky flag raised by a minute carry;
- a 30 s low / 30 s high square wave aligned to minute carries;
- a sticky hour/minute alarm.

A single 16-bit configuration word does two jobs. It is an hour/minute compare value in alarm mode and a tap mask in frequency mode.

The block sits beside a time-keeping counter. It receives the current BCD hour and minute, the one-cycle minute-carry pulse and the sixteen divider taps. The register file that holds the configuration word sits outside the block, and so does the divider. The mode bits are held here and are loaded by a write strobe. To get two independent interrupt lines, instantiate the block twice with different reset parameters. The first line resets into frequency mode, which gives a 1 Hz trimming clock when its word holds 8000h. The second line resets into the off mode.

Top module: `irq_out_ctrl`

## Requirements
- R1: The mode bits {arm, minute, free-run} decode as follows: minute=1 and free-run=1 give square mode; minute=1 and free-run=0 give edge mode; minute=0 and free-run=1 give frequency mode; all three at 0 give off; arm=1 with the other two at 0 gives alarm. The arm bit has no effect in the first three modes.
- R2: While reset is held, `pullLow` is 0. The mode bits reset to the parameters `RST_AE`, `RST_ME` and `RST_FE`; the defaults are 0, 0 and 1, which select frequency mode.
- R3: In alarm mode, a match occurs when `hourBcd` equals `cfgWord[15:8]` (bit 15 is the AM/PM flag and takes part in the compare) and `minuteBcd` equals `cfgWord[7:0]`. `pullLow` rises on the second clock edge after a match appears. It then stays 1 while the mode stays alarm, even after the time moves on.
- R4: A mode write that leaves alarm mode clears the alarm output. Re-entering alarm mode while the time still matches raises it again. Re-entering once the time no longer matches leaves it at 0.
- R5: In frequency mode, `divTaps[i]` is the tap at 32768/2^i Hz. The line level is the AND of every tap whose `cfgWord[i]` is 1. `pullLow` is the inverse of that level, registered once.
- R6: In frequency mode with `cfgWord` equal to 0, `pullLow` stays 0 whatever the taps do.
- R7: A carry window lasts `CARRY_HOLD` cycles and starts with the cycle in which `minuteCarry` is 1. In edge mode, any cycle inside the window latches the output to 1. The output then holds until the mode bits select another mode, and later carries do not clear it.
- R8: Entering edge mode while a carry window is still open raises the output. Entering it after the window has closed does not.
- R9: In square mode, a minute carry drives `pullLow` to 1. `pullLow` returns to 0 on the `HALF_SECS`-th rising edge of `divTaps[15]` after that carry and stays 0 until the next carry.
- R10: A mode write that changes the bits clears the square-wave phase. After square mode is entered, `pullLow` stays 0 until the first minute carry, even while `divTaps[15]` toggles.
- R11: In off mode, `pullLow` is 0 whatever the time, carry, taps and configuration word do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| statusWr | input | 1 | One-cycle strobe that loads the three mode bits |
| aeIn | input | 1 | Arm bit value to load |
| meIn | input | 1 | Minute bit value to load |
| feIn | input | 1 | Free-run bit value to load |
| hourBcd | input | 8 | Current hour in BCD, with AM/PM in bit 7 |
| minuteBcd | input | 8 | Current minute in BCD |
| cfgWord | input | 16 | Alarm hour/minute, or the tap mask in frequency mode |
| minuteCarry | input | 1 | One-cycle pulse at each minute rollover |
| divTaps | input | 16 | Divider taps; bit i runs at 32768/2^i Hz |
| pullLow | output | 1 | 1 when the interrupt line must be pulled low |

## Verification
The frequency path is swept with six tap masks and 256 scrambled tap vectors each. The masks are:
- the two-tap example 000Ah;
- a single top tap;
- a single bottom tap;
- all taps;
- one nibble;
- a checkerboard.

Together these separate AND from OR and catch wrong bit order or polarity. A zero-mask sweep shows that an empty selection stays quiet.

For the alarm, the minute value is swept from 00 to 29 under a matching hour, which shows that a partial match never fires. A compare with the AM/PM flag cleared separates a full-byte hour compare from one that ignores bit 7.

The carry-driven modes are tried with arming before, inside and after a carry window, and with phase resets in the middle of a period. These runs distinguish latching from level-following and show that square mode really waits for the first carry.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_FREQ,
    MODE_EDGE,
    MODE_SQUARE,
    MODE_ALARM
  } irqMode_e;

  // strobes from control to datapath for the square-wave phase counter
  typedef struct packed {
    logic phaseClear;
    logic phaseRestart;
    logic phaseRun;
  } phaseStrobe_t;

  function automatic irqMode_e decodeMode(input logic ae, input logic me, input logic fe);
    irqMode_e m;
    if (me && fe)        m = MODE_SQUARE;
    else if (me)         m = MODE_EDGE;
    else if (fe)         m = MODE_FREQ;
    else if (ae)         m = MODE_ALARM;
    else                 m = MODE_OFF;
    return m;
  endfunction

endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_out_pkg::*;
#(
  parameter int TAPS       = 16,
  parameter int HALF_SECS  = 30,
  parameter int CARRY_HOLD = 328
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         hourBcd,
  input  logic [7:0]         minuteBcd,
  input  logic [TAPS-1:0]    cfgWord,
  input  logic               minuteCarry,
  input  logic [TAPS-1:0]    divTaps,
  input  phaseStrobe_t       strobes,
  output logic               alarmHit,
  output logic               carryActive,
  output logic               freqPull,
  output logic               halfDone
);

  localparam int HALF_W  = $clog2(HALF_SECS + 1);
  localparam int CARRY_W = $clog2(CARRY_HOLD + 1);
  localparam int SEC_TAP = TAPS - 1;

  // alarm compare: full hour byte (AM/PM included) and minute byte
  assign alarmHit = (hourBcd == cfgWord[15:8]) && (minuteBcd == cfgWord[7:0]);

  // frequency: AND over selected taps, unselected taps forced to pass
  logic [TAPS-1:0] tapPass;
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tapPass[i] = divTaps[i] | ~cfgWord[i];
  end
  assign freqPull = (|cfgWord) && !(&tapPass);

  // carry window
  logic [CARRY_W-1:0] carryCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             carryCnt <= '0;
    else if (minuteCarry)  carryCnt <= CARRY_W'(CARRY_HOLD - 1);
    else if (carryCnt != 0) carryCnt <= carryCnt - 1'b1;
  end
  assign carryActive = minuteCarry || (carryCnt != 0);

  // seconds from the slowest tap
  logic secPrev;
  logic secTick;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) secPrev <= 1'b0;
    else       secPrev <= divTaps[SEC_TAP];
  end
  assign secTick = divTaps[SEC_TAP] && !secPrev;

  // half-period counter
  logic [HALF_W-1:0] halfCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      halfCnt <= '0;
    else if (strobes.phaseClear || strobes.phaseRestart) halfCnt <= '0;
    else if (strobes.phaseRun && secTick) begin
      if (halfDone) halfCnt <= '0;
      else          halfCnt <= halfCnt + 1'b1;
    end
  end
  assign halfDone = strobes.phaseRun && secTick && (halfCnt == HALF_W'(HALF_SECS - 1));

  // R9
  half_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    halfCnt < HALF_W'(HALF_SECS));

  // R7
  carry_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    minuteCarry |=> (carryCnt == CARRY_W'(CARRY_HOLD - 1)));

  // R6
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord == '0) |-> !freqPull);

endmodule

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl
  import irq_out_pkg::*;
#(
  parameter bit RST_AE = 1'b0,
  parameter bit RST_ME = 1'b0,
  parameter bit RST_FE = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         statusWr,
  input  logic         aeIn,
  input  logic         meIn,
  input  logic         feIn,
  input  logic         alarmHit,
  input  logic         carryActive,
  input  logic         minuteCarry,
  input  logic         freqPull,
  input  logic         halfDone,
  output phaseStrobe_t strobes,
  output logic         pullLow
);

  localparam logic [2:0] RST_BITS = {RST_AE, RST_ME, RST_FE};

  logic [2:0] modeBits;
  irqMode_e   mode;
  logic       wrChange;
  logic       alarmLatch;
  logic       edgeLatch;
  logic       sqLow;
  logic       nextPull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeBits <= RST_BITS;
    else if (statusWr) modeBits <= {aeIn, meIn, feIn};
  end

  assign mode     = decodeMode(modeBits[2], modeBits[1], modeBits[0]);
  assign wrChange = statusWr && ({aeIn, meIn, feIn} != modeBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   alarmLatch <= 1'b0;
    else if (mode != MODE_ALARM) alarmLatch <= 1'b0;
    else if (alarmHit)           alarmLatch <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   edgeLatch <= 1'b0;
    else if (mode != MODE_EDGE)  edgeLatch <= 1'b0;
    else if (carryActive)        edgeLatch <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  sqLow <= 1'b0;
    else if (wrChange || mode != MODE_SQUARE)   sqLow <= 1'b0;
    else if (minuteCarry)                       sqLow <= 1'b1;
    else if (halfDone)                          sqLow <= 1'b0;
  end

  assign strobes.phaseClear   = wrChange || (mode != MODE_SQUARE);
  assign strobes.phaseRestart = (mode == MODE_SQUARE) && minuteCarry;
  assign strobes.phaseRun     = sqLow;

  always_comb begin
    unique case (mode)
      MODE_FREQ:   nextPull = freqPull;
      MODE_EDGE:   nextPull = edgeLatch;
      MODE_SQUARE: nextPull = sqLow;
      MODE_ALARM:  nextPull = alarmLatch;
      default:     nextPull = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pullLow <= 1'b0;
    else       pullLow <= nextPull;
  end

  // R3
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ALARM && alarmLatch) |=> alarmLatch);

  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_EDGE && edgeLatch) |=> edgeLatch);

  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |=> !pullLow);

  // R9
  sq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sqLow) |-> $past(halfDone || wrChange || mode != MODE_SQUARE));

endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl
  import irq_out_pkg::*;
#(
  parameter int HALF_SECS  = 30,
  parameter int CARRY_HOLD = 328,
  parameter bit RST_AE     = 1'b0,
  parameter bit RST_ME     = 1'b0,
  parameter bit RST_FE     = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        statusWr,
  input  logic        aeIn,
  input  logic        meIn,
  input  logic        feIn,
  input  logic [7:0]  hourBcd,
  input  logic [7:0]  minuteBcd,
  input  logic [15:0] cfgWord,
  input  logic        minuteCarry,
  input  logic [15:0] divTaps,
  output logic        pullLow
);

  localparam int TAPS = 16;

  phaseStrobe_t strobes;
  logic alarmHit, carryActive, freqPull, halfDone;

  irq_datapath #(
    .TAPS(TAPS), .HALF_SECS(HALF_SECS), .CARRY_HOLD(CARRY_HOLD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hourBcd(hourBcd), .minuteBcd(minuteBcd),
    .cfgWord(cfgWord), .minuteCarry(minuteCarry), .divTaps(divTaps),
    .strobes(strobes), .alarmHit(alarmHit), .carryActive(carryActive),
    .freqPull(freqPull), .halfDone(halfDone)
  );

  irq_mode_ctrl #(
    .RST_AE(RST_AE), .RST_ME(RST_ME), .RST_FE(RST_FE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .statusWr(statusWr), .aeIn(aeIn), .meIn(meIn),
    .feIn(feIn), .alarmHit(alarmHit), .carryActive(carryActive),
    .minuteCarry(minuteCarry), .freqPull(freqPull), .halfDone(halfDone),
    .strobes(strobes), .pullLow(pullLow)
  );

endmodule

// File: tb/irq_out_ctrl_tb.sv
`timescale 1ns/1ps
module irq_out_ctrl_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, statusWr, aeIn, meIn, feIn, minuteCarry;
  logic [7:0]  hourBcd, minuteBcd;
  logic [15:0] cfgWord, divTaps;
  logic        pullLow, pullLow2;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  irq_out_ctrl #(.HALF_SECS(4), .CARRY_HOLD(8)) u_dut (
    .clk(clk), .rstN(rstN), .statusWr(statusWr), .aeIn(aeIn), .meIn(meIn),
    .feIn(feIn), .hourBcd(hourBcd), .minuteBcd(minuteBcd), .cfgWord(cfgWord),
    .minuteCarry(minuteCarry), .divTaps(divTaps), .pullLow(pullLow));

  irq_out_ctrl #(.HALF_SECS(4), .CARRY_HOLD(8), .RST_FE(1'b0)) u_dut2 (
    .clk(clk), .rstN(rstN), .statusWr(statusWr), .aeIn(aeIn), .meIn(meIn),
    .feIn(feIn), .hourBcd(hourBcd), .minuteBcd(minuteBcd), .cfgWord(cfgWord),
    .minuteCarry(minuteCarry), .divTaps(divTaps), .pullLow(pullLow2));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeMode(input logic ae, input logic me, input logic fe);
    statusWr = 1'b1; aeIn = ae; meIn = me; feIn = fe;
    @(negedge clk);
    statusWr = 1'b0;
  endtask

  task automatic pulseCarry();
    minuteCarry = 1'b1;
    @(negedge clk);
    minuteCarry = 1'b0;
  endtask

  task automatic secPulse();
    divTaps[15] = 1'b1;
    @(negedge clk);
    divTaps[15] = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic expFreq(input logic [15:0] mask, input logic [15:0] taps);
    return (mask != 16'h0) && ((taps & mask) != mask);
  endfunction

  initial begin
    cyc(150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] masks [6];
    masks = '{16'h000A, 16'h8000, 16'h0001, 16'hFFFF, 16'h00F0, 16'hA5A5};
    rstN = 1'b0; statusWr = 0; aeIn = 0; meIn = 0; feIn = 0; minuteCarry = 0;
    hourBcd = 8'h00; minuteBcd = 8'h00; cfgWord = 16'h8000; divTaps = 16'h0000;
    cyc(3);
    check("R2 reset line1", pullLow, 1'b0);
    check("R2 reset line2", pullLow2, 1'b0);
    rstN = 1'b1;

    // R2: default parameters give frequency mode, 1 Hz tap with word 8000h
    for (int t = 0; t < 4; t++) begin
      divTaps[15] = t[0];
      cyc(1);
      check("R2 1Hz line1", pullLow, !t[0]);
      check("R2 line2 off", pullLow2, 1'b0);
    end

    // R5: mask sweep
    foreach (masks[m]) begin
      for (int k = 0; k < 256; k++) begin
        logic [15:0] tv;
        tv = 16'(k * 40503) ^ 16'(k << 7);
        cfgWord = masks[m]; divTaps = tv;
        cyc(1);
        check("R5 freq sweep", pullLow, expFreq(masks[m], tv));
      end
    end
    cfgWord = 16'h000A; divTaps = 16'h000A; cyc(1);
    check("R5 000A both high", pullLow, 1'b0);
    divTaps = 16'h0002; cyc(1);
    check("R5 000A one low", pullLow, 1'b1);

    // R6: empty mask
    cfgWord = 16'h0000;
    for (int k = 0; k < 64; k++) begin
      divTaps = 16'(k * 1021);
      cyc(1);
      check("R6 zero mask", pullLow, 1'b0);
    end

    // R11: off mode ignores everything
    writeMode(0, 0, 0);
    cfgWord = 16'h8530; hourBcd = 8'h85; minuteBcd = 8'h30;
    divTaps = 16'h0000; cyc(2);
    check("R11 off match", pullLow, 1'b0);
    pulseCarry(); cyc(3);
    check("R11 off carry", pullLow, 1'b0);

    // R1: arm bit ignored with free-run set (frequency, all taps high)
    divTaps = 16'hFFFF;
    writeMode(1, 0, 1); cyc(3);
    check("R1 ae+fe is freq", pullLow, 1'b0);
    divTaps = 16'h0000; cyc(1);
    check("R1 ae+fe freq low tap", pullLow, 1'b1);
    writeMode(1, 1, 0); cyc(3);
    check("R1 ae+me is edge", pullLow, 1'b0);

    // R3: alarm
    minuteBcd = 8'h00;
    writeMode(1, 0, 0);
    hourBcd = 8'h05; minuteBcd = 8'h30; cyc(3);
    check("R3 AM/PM mismatch", pullLow, 1'b0);
    hourBcd = 8'h85;
    for (int t = 0; t < 30; t++) begin
      minuteBcd = {4'(t / 10), 4'(t % 10)};
      cyc(2);
      check("R3 minute sweep no match", pullLow, 1'b0);
    end
    minuteBcd = 8'h30; cyc(1);
    check("R3 first edge", pullLow, 1'b0);
    cyc(1);
    check("R3 second edge", pullLow, 1'b1);
    minuteBcd = 8'h31; cyc(3);
    check("R3 held after match", pullLow, 1'b1);

    // R4
    writeMode(0, 0, 0); cyc(2);
    check("R4 disarm clears", pullLow, 1'b0);
    writeMode(1, 0, 0); cyc(3);
    check("R4 rearm no match", pullLow, 1'b0);
    minuteBcd = 8'h30;
    writeMode(0, 0, 0); cyc(1);
    writeMode(1, 0, 0); cyc(3);
    check("R4 rearm in minute", pullLow, 1'b1);
    minuteBcd = 8'h31;

    // R7
    writeMode(0, 1, 0); cyc(3);
    check("R7 edge idle", pullLow, 1'b0);
    pulseCarry(); cyc(2);
    check("R7 edge set", pullLow, 1'b1);
    cyc(20);
    check("R7 edge held", pullLow, 1'b1);
    pulseCarry(); cyc(12);
    check("R7 edge held after carry", pullLow, 1'b1);

    // R8
    writeMode(0, 0, 0); cyc(2);
    check("R8 cleared", pullLow, 1'b0);
    pulseCarry(); cyc(2);
    writeMode(0, 1, 0); cyc(3);
    check("R8 enable inside window", pullLow, 1'b1);
    writeMode(0, 0, 0); cyc(2);
    pulseCarry(); cyc(12);
    writeMode(0, 1, 0); cyc(3);
    check("R8 enable after window", pullLow, 1'b0);

    // R9 / R10
    divTaps = 16'h0000;
    writeMode(0, 1, 1); cyc(2);
    check("R10 square idle", pullLow, 1'b0);
    repeat (3) secPulse();
    check("R10 waits for carry", pullLow, 1'b0);
    pulseCarry(); cyc(1);
    check("R9 low at carry", pullLow, 1'b1);
    repeat (3) secPulse();
    check("R9 low before half", pullLow, 1'b1);
    secPulse(); cyc(1);
    check("R9 high after half", pullLow, 1'b0);
    repeat (5) secPulse();
    check("R9 stays high", pullLow, 1'b0);
    pulseCarry(); cyc(1);
    check("R9 next period", pullLow, 1'b1);
    cfgWord = 16'h0000;
    writeMode(0, 0, 1); cyc(1);
    writeMode(0, 1, 1); cyc(3);
    check("R10 phase cleared", pullLow, 1'b0);
    repeat (2) secPulse();
    check("R10 still waiting", pullLow, 1'b0);
    pulseCarry(); cyc(1);
    check("R10 resumes on carry", pullLow, 1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule